// File: doc/BRIEF.md
# Scan Line Capture and Readout Controller

This block steers two transfer channels that share one image memory. The capture channel takes digitized sensor samples and writes them into the memory one scan line at a time. It starts at a start address that the CPU programs, and the address steps up by one for each stored byte. The readout channel serves a host port. In image mode, each host read consumes one byte of captured image data. Otherwise host accesses are plain memory traffic and leave the image bookkeeping alone.

A count of valid image bytes links the two channels. Capture adds to it and image-mode host reads take from it. Capture refuses any byte that would push the count past a programmed buffer size. When that happens it stops and raises a sticky interrupt. The capture enable clears itself when a line is complete, so the CPU can poll it to find the end of the line. A line marked as the last one also takes the host channel out of image mode when it finishes.

Top module: `scan_dma`

## Requirements
- R1: After reset, `ctrl_q` is 0, `valid_cnt` is 0, `irq` is 0 and `mem_we` is 0.
- R2: A CPU write to register 0 loads `ctrl_q` on the next clock edge. Bit 0 is the download enable, bit 1 the capture enable, bit 2 image-read mode and bit 3 the last-line flag. Register 1 holds the start address, register 2 the buffer size and register 3 the line length in bytes.
- R3: While capture is enabled, a valid sample is written in the same cycle (`mem_we`=1, `mem_wdata`=sample). The first address is the start address held when the capture enable was written as 1. Each later stored byte uses the previous address plus one, wrapping at the address width.
- R4: After the stored byte that completes the line length, `ctrl_q[1]` reads 0 on the next cycle, and later samples are not written.
- R5: If `ctrl_q[3]` is 1 when a line completes, `ctrl_q[2]` is cleared together with the capture enable; otherwise `ctrl_q[2]` is kept.
- R6: Each stored byte raises `valid_cnt` by one on the next cycle.
- R7: With `ctrl_q[2]`=1, a host read while `valid_cnt` is nonzero lowers `valid_cnt` by one on the next cycle; at zero it stays zero.
- R8: With `ctrl_q[2]`=0, host reads leave `valid_cnt` unchanged.
- R9: A sample arriving while capture is enabled counts as an overrun if valid_cnt + 1 − (image read this cycle) would exceed the buffer size. On an overrun the byte is not written, and on the next cycle `ctrl_q[1]` is 0, `irq` is 1 and `valid_cnt` is unchanged.
- R10: `irq` stays set until a CPU write to register 0 with bit 7 set clears it; a register-0 write with bit 7 clear leaves it set.
- R11: A stored byte and an image-mode host read in the same cycle leave `valid_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | CPU register select |
| cpu_wdata | input | 8 | CPU write data |
| ctrl_q | output | 4 | Control bits {last, image-read, capture, download} |
| irq | output | 1 | Sticky overrun interrupt |
| smp_valid | input | 1 | Front-end sample valid |
| smp_data | input | DATA_W | Front-end sample byte |
| host_rd | input | 1 | Host read strobe |
| valid_cnt | output | CNT_W | Count of valid image bytes |
| mem_we | output | 1 | Image memory write enable |
| mem_addr | output | ADDR_W | Image memory write address |
| mem_wdata | output | DATA_W | Image memory write data |

## Verification
The memory write port is combinational, so the bench drives each sample just after a falling edge and checks `mem_we`, `mem_addr` and `mem_wdata` one time unit later, in that same cycle. The count, the control bits and the interrupt are all registered. The bench therefore checks them at the next falling edge, one clock after the stimulus that caused them. A running model of the count, written as plain arithmetic, supplies every expected value, including the cases where a store coincides with a read and where an overrun is refused.

// File: rtl/scan_dma_pkg.sv
package scan_dma_pkg;
  localparam int CPU_W = 8;

  typedef struct packed {
    logic last;
    logic img;
    logic cap;
    logic dl;
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_START = 2'd1,
    REG_SIZE  = 2'd2,
    REG_LEN   = 2'd3
  } reg_sel_e;

  localparam int IRQ_CLR_BIT = 7;
endpackage

// File: rtl/scan_dma_regs.sv
module scan_dma_regs
  import scan_dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [CPU_W-1:0]  cpu_wdata,
  input  logic              ev_line_end,
  input  logic              ev_overrun,
  output ctrl_t             ctrl,
  output logic              cap_load,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  buf_size,
  output logic [LEN_W-1:0]  line_len,
  output logic              irq
);
  logic wr_ctrl;
  assign wr_ctrl  = cpu_wr && (cpu_addr == REG_CTRL);
  assign cap_load = wr_ctrl && cpu_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      start_addr <= '0;
      buf_size   <= '0;
      line_len   <= '0;
      irq        <= 1'b0;
    end else begin
      if (ev_line_end) begin
        ctrl.cap <= 1'b0;
        if (ctrl.last) ctrl.img <= 1'b0;
      end
      if (ev_overrun) ctrl.cap <= 1'b0;
      if (wr_ctrl) ctrl <= ctrl_t'(cpu_wdata[3:0]);
      if (cpu_wr && cpu_addr == REG_START) start_addr <= cpu_wdata[ADDR_W-1:0];
      if (cpu_wr && cpu_addr == REG_SIZE)  buf_size   <= cpu_wdata[CNT_W-1:0];
      if (cpu_wr && cpu_addr == REG_LEN)   line_len   <= cpu_wdata[LEN_W-1:0];
      if (wr_ctrl && cpu_wdata[IRQ_CLR_BIT]) irq <= 1'b0;
      if (ev_overrun) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_dma_capture.sv
module scan_dma_capture #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  line_len,
  input  logic [CNT_W-1:0]  buf_size,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dec,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              ev_store,
  output logic              ev_line_end,
  output logic              ev_overrun,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic [ADDR_W-1:0] wr_ptr;
  logic [LEN_W-1:0]  line_cnt;

  function automatic logic would_exceed(input logic [CNT_W-1:0] c,
                                        input logic d,
                                        input logic [CNT_W-1:0] size);
    return ({1'b0, c} + (CNT_W+1)'(1)) > ({1'b0, size} + (CNT_W+1)'(d));
  endfunction

  function automatic logic is_line_last(input logic [LEN_W-1:0] n,
                                        input logic [LEN_W-1:0] len);
    return ({1'b0, n} + (LEN_W+1)'(1)) == {1'b0, len};
  endfunction

  logic take;
  assign take        = cap_en && smp_valid;
  assign ev_overrun  = take && would_exceed(cnt, dec, buf_size);
  assign ev_store    = take && !ev_overrun;
  assign ev_line_end = ev_store && is_line_last(line_cnt, line_len);

  assign mem_we    = ev_store;
  assign mem_addr  = wr_ptr;
  assign mem_wdata = smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      line_cnt <= '0;
    end else if (cap_load) begin
      wr_ptr   <= start_addr;
      line_cnt <= '0;
    end else if (ev_store) begin
      wr_ptr   <= wr_ptr + 1'b1;
      line_cnt <= ev_line_end ? '0 : line_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scan_dma_count.sv
module scan_dma_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             img_mode,
  input  logic             host_rd,
  output logic             dec,
  output logic [CNT_W-1:0] cnt
);
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic i,
                                                input logic d);
    case ({i, d})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign dec = img_mode && host_rd && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next(cnt, inc, dec);
  end
endmodule

// File: rtl/scan_dma.sv
module scan_dma
  import scan_dma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [CPU_W-1:0]  cpu_wdata,
  output logic [3:0]        ctrl_q,
  output logic              irq,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              host_rd,
  output logic [CNT_W-1:0]  valid_cnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  ctrl_t             ctrl;
  logic              cap_load;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  buf_size;
  logic [LEN_W-1:0]  line_len;
  logic              ev_store;
  logic              ev_line_end;
  logic              ev_overrun;
  logic              ev_img_read;

  assign ctrl_q = ctrl;

  scan_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ev_line_end(ev_line_end), .ev_overrun(ev_overrun),
    .ctrl(ctrl), .cap_load(cap_load), .start_addr(start_addr),
    .buf_size(buf_size), .line_len(line_len), .irq(irq)
  );

  scan_dma_capture #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
                     .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(ctrl.cap), .cap_load(cap_load),
    .start_addr(start_addr), .line_len(line_len), .buf_size(buf_size),
    .cnt(valid_cnt), .dec(ev_img_read), .smp_valid(smp_valid),
    .smp_data(smp_data), .ev_store(ev_store), .ev_line_end(ev_line_end),
    .ev_overrun(ev_overrun), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  scan_dma_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_store), .img_mode(ctrl.img),
    .host_rd(host_rd), .dec(ev_img_read), .cnt(valid_cnt)
  );
endmodule

// File: rtl/scan_dma_chk.sv
module scan_dma_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic [1:0]        cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic [3:0]        ctrl_q,
  input logic              irq,
  input logic              host_rd,
  input logic [CNT_W-1:0]  valid_cnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_store,
  input logic              ev_line_end,
  input logic              ev_overrun,
  input logic              ev_img_read
);
  logic wr_ctrl;
  assign wr_ctrl = cpu_wr && cpu_addr == 2'd0;

  AST_WE_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ctrl_q[1]); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !wr_ctrl) |=> (!mem_we || mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R3
  AST_LINE_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line_end && !wr_ctrl) |=> !ctrl_q[1]); // R4
  AST_LAST_LINE_IMG: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_line_end && ctrl_q[3] && !wr_ctrl) |=> !ctrl_q[2]); // R5
  AST_STORE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store && !ev_img_read) |=> valid_cnt == CNT_W'($past(valid_cnt) + 1'b1)); // R6
  AST_MODE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !ev_store) |=> $stable(valid_cnt)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |-> !mem_we); // R9
  AST_OVR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overrun && !wr_ctrl) |=> (irq && !ctrl_q[1])); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_ctrl && cpu_wdata[7])) |=> irq); // R10
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_store && ev_img_read) |=> $stable(valid_cnt)); // R11
  AST_RD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_img_read |-> (ctrl_q[2] && host_rd)); // R7
endmodule

bind scan_dma scan_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/scan_dma_bench.sv
module scan_dma_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [3:0] ctrl_q;
  logic       irq;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic       host_rd = 1'b0;
  logic [7:0] valid_cnt;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_dma u_scan_dma (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ctrl_q(ctrl_q), .irq(irq), .smp_valid(smp_valid),
    .smp_data(smp_data), .host_rd(host_rd), .valid_cnt(valid_cnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // One sample in one cycle; write port checked in-cycle, registers at next negedge.
  task automatic sample(input logic [7:0] d, input bit rd, input bit exp_we,
                        input logic [7:0] exp_addr, input string req);
    smp_valid = 1'b1; smp_data = d; host_rd = rd;
    #1;
    chk(mem_we == exp_we, req, mem_we, exp_we);
    if (exp_we) begin
      chk(mem_addr == exp_addr, req, mem_addr, exp_addr);
      chk(mem_wdata == d, req, mem_wdata, d);
    end
    @(negedge clk);
    smp_valid = 1'b0; host_rd = 1'b0;
  endtask

  task automatic host_read;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic run_line(input logic [7:0] start, input int len, input bit last);
    cpu_write(2'd1, start);
    cpu_write(2'd3, 8'(len));
    cpu_write(2'd0, {4'b0, last, 3'b110});
    for (int i = 0; i < len; i++) begin
      sample(8'(start + i + 8'h33), 1'b0, 1'b1, 8'(start + i), "R3");
      exp_cnt++;
      chk(valid_cnt == 8'(exp_cnt), "R6", valid_cnt, exp_cnt);
    end
    chk(ctrl_q[1] == 1'b0, "R4", ctrl_q[1], 0);
    chk(ctrl_q[2] == !last, "R5", ctrl_q[2], !last);
    sample(8'h5A, 1'b0, 1'b0, 8'h00, "R4");
    chk(valid_cnt == 8'(exp_cnt), "R4", valid_cnt, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(ctrl_q == 4'b0, "R1", ctrl_q, 0);
    chk(valid_cnt == 8'd0, "R1", valid_cnt, 0);
    chk(irq == 1'b0, "R1", irq, 0);
    chk(mem_we == 1'b0, "R1", mem_we, 0);

    // R2 register layout
    cpu_write(2'd0, 8'h09);
    chk(ctrl_q == 4'b1001, "R2", ctrl_q, 9);
    cpu_write(2'd1, 8'h10);
    cpu_write(2'd2, 8'd6);
    cpu_write(2'd3, 8'd4);
    cpu_write(2'd0, 8'h06);
    chk(ctrl_q == 4'b0110, "R2", ctrl_q, 6);

    // R3/R4/R6 first line of 4 bytes
    for (int i = 0; i < 4; i++) begin
      sample(8'(8'hA0 + i), 1'b0, 1'b1, 8'(8'h10 + i), "R3");
      exp_cnt++;
      chk(valid_cnt == 8'(exp_cnt), "R6", valid_cnt, exp_cnt);
    end
    chk(ctrl_q[1] == 1'b0, "R4", ctrl_q[1], 0);
    chk(ctrl_q[2] == 1'b1, "R5", ctrl_q[2], 1);
    sample(8'hEE, 1'b0, 1'b0, 8'h00, "R4");
    chk(valid_cnt == 8'd4, "R4", valid_cnt, 4);

    // R7 image reads
    host_read; exp_cnt--;
    chk(valid_cnt == 8'(exp_cnt), "R7", valid_cnt, exp_cnt);
    host_read; exp_cnt--;
    chk(valid_cnt == 8'(exp_cnt), "R7", valid_cnt, exp_cnt);

    // R8 plain memory mode
    cpu_write(2'd0, 8'h00);
    host_read;
    chk(valid_cnt == 8'(exp_cnt), "R8", valid_cnt, exp_cnt);
    host_read;
    chk(valid_cnt == 8'(exp_cnt), "R8", valid_cnt, exp_cnt);

    // R11 simultaneous store and image read, then R9 overrun at size 6
    cpu_write(2'd3, 8'd10);
    cpu_write(2'd0, 8'h06);
    sample(8'h11, 1'b1, 1'b1, 8'h10, "R11");
    chk(valid_cnt == 8'(exp_cnt), "R11", valid_cnt, exp_cnt);
    for (int i = 1; i <= 4; i++) begin
      sample(8'(8'h11 + i), 1'b0, 1'b1, 8'(8'h10 + i), "R3");
      exp_cnt++;
    end
    chk(valid_cnt == 8'd6, "R6", valid_cnt, 6);
    chk(ctrl_q[1] == 1'b1, "R9", ctrl_q[1], 1);
    sample(8'h77, 1'b0, 1'b0, 8'h00, "R9");
    chk(ctrl_q[1] == 1'b0, "R9", ctrl_q[1], 0);
    chk(irq == 1'b1, "R9", irq, 1);
    chk(valid_cnt == 8'd6, "R9", valid_cnt, 6);

    // R9 boundary: store with concurrent read at full buffer is accepted
    cpu_write(2'd0, 8'h06);
    sample(8'h78, 1'b1, 1'b1, 8'h10, "R9");
    chk(valid_cnt == 8'd6, "R11", valid_cnt, 6);

    // R10 sticky interrupt
    cpu_write(2'd0, 8'h04);
    chk(irq == 1'b1, "R10", irq, 1);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R10", irq, 1);
    cpu_write(2'd0, 8'h84);
    chk(irq == 1'b0, "R10", irq, 0);
    chk(ctrl_q == 4'b0100, "R2", ctrl_q, 4);

    // R7 drain to zero, then read at zero holds
    while (exp_cnt > 0) begin
      host_read; exp_cnt--;
    end
    chk(valid_cnt == 8'd0, "R7", valid_cnt, 0);
    host_read;
    chk(valid_cnt == 8'd0, "R7", valid_cnt, 0);

    // Sweep: line lengths, last-line flag, start addresses incl. wrap
    cpu_write(2'd2, 8'd255);
    for (int len = 1; len <= 5; len++) begin
      for (int last = 0; last < 2; last++) begin
        run_line(8'(8'hFC + len * 7), len, last[0]);
      end
    end
    run_line(8'hFE, 4, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule